// File: doc/BRIEF.md
# Beam-Synchronized Register-Write Coprocessor

This block runs a small program of 32-bit instructions fetched from memory, pacing itself by the position of the video beam. Each instruction is two 16-bit words read in sequence through a request/grant memory port that returns one word in every granted cycle. Three instructions exist. A MOVE puts a 16-bit value on a register write port toward the peripheral bus. A WAIT holds execution until the beam reaches a programmed position. A SKIP steps over the following instruction when the beam is already past a programmed position. The engine can only write registers. It never reads them and never writes memory.

Two list start pointers are loaded from outside. Execution restarts from the first pointer on every frame-start pulse. A jump strobe restarts execution from either pointer. Beam positions are compared through per-bit masks. The MOVE target range is guarded: a low offset stops the program, and a middle range is allowed only while a danger enable input is high. A dedicated end-of-list WAIT parks the engine until the next restart. When the DMA enable input is low, the engine freezes in place.

Top module: `beam_coproc`

## Requirements
- R1: A first word with bit 0 clear is a MOVE. Its second word is written to register offset {word1[8:1], 0}. reg_we is high for one cycle, in the cycle after the second word is granted.
- R2: Each instruction word uses exactly one cycle in which mem_req and mem_gnt are both high. Without a grant nothing advances. With the grant held high, back-to-back MOVEs produce writes exactly two cycles apart.
- R3: A WAIT has word1 = {v[7:0], h[6:0], 1} and word2 = {unused, vmask[6:0], hmask[6:0], 0}. The engine issues no request while the beam is below the target. The fetch of the next instruction starts the cycle after the beam first reaches the target, with equality counting as reached.
- R4: The compare orders {beam_v[7], beam_v[6:0]&vmask, beam_h&hmask} against the same masking of the target. A cleared mask bit removes that bit from both sides. Vertical bit 7 is always compared.
- R5: A SKIP is a WAIT-format instruction with word2 bit 0 set. If the beam has reached its target in the cycle its second word is granted, the next instruction is not executed. Otherwise execution continues with the next instruction.
- R6: The WAIT pair 0xFFFF, 0xFFFE ends the list. The engine then makes no request and no write until a restart.
- R7: A frame_start pulse restarts execution from list pointer 1. It overrides any jump strobe in the same cycle.
- R8: A jump_req pulse restarts execution from pointer 1 when jump_sel is 0, or from pointer 2 when jump_sel is 1. Pointers are written through ptr_we, with ptr_sel choosing the pointer in the same way.
- R9: A MOVE to an offset below 0x040 writes nothing and halts the engine. A MOVE to an offset in 0x040–0x07E does the same unless danger_en is high. The engine stays halted until a restart.
- R10: While dma_en is low, mem_req stays low and the program position and state do not change. After dma_en returns, execution resumes with no instruction lost or repeated.
- R11: After reset, no request and no write are made until a restart, and both pointers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per color-clock slot |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Allows fetching and execution |
| danger_en | input | 1 | Permits MOVEs to offsets 0x040–0x07E |
| ptr_we | input | 1 | Writes ptr_wdata into the selected list pointer |
| ptr_sel | input | 1 | Pointer select for ptr_we (0 = list 1, 1 = list 2) |
| ptr_wdata | input | 20 | Byte address of a list start |
| frame_start | input | 1 | Frame restart pulse, reloads from pointer 1 |
| jump_req | input | 1 | Jump strobe |
| jump_sel | input | 1 | Jump target (0 = list 1, 1 = list 2) |
| beam_v | input | 8 | Vertical beam position |
| beam_h | input | 7 | Horizontal beam position in two-color-clock units |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | 20 | Byte address of the word being fetched |
| mem_gnt | input | 1 | Grant; mem_rdata is valid in the same cycle |
| mem_rdata | input | 16 | Fetched word |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 9 | Register byte offset |
| reg_wdata | output | 16 | Register write data |

## Verification
Every result has a fixed latency. A MOVE reaches reg_we two edges after the cycle in which its first word is granted. It is three edges after a restart pulse, or after the beam change that releases a WAIT. It is one edge after dma_en returns when the second word was pending. The bench drives and samples on the falling edge and counts falling edges. Each observed write is logged with its edge number, and the checks compare that number with the offset worked out from these latencies. They also compare the count, order, offsets and data of the writes. Checks on stalls, halts and freezes sample mem_req and count writes over a window of several cycles.

// File: rtl/coproc_pkg.sv
package coproc_pkg;

    localparam int WORD_W  = 16;
    localparam int REG_AW  = 9;
    localparam int MASK_W  = 7;
    localparam logic [REG_AW-1:0] DANGER_FLOOR = 9'h040;
    localparam logic [REG_AW-1:0] SAFE_FLOOR   = 9'h080;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_FETCH1 = 2'd1,
        ST_FETCH2 = 2'd2,
        ST_WAIT   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [7:0]        v;
        logic [MASK_W-1:0] h;
        logic [MASK_W-1:0] vmask;
        logic [MASK_W-1:0] hmask;
        logic              skip;
    } beam_tgt_t;

    function automatic beam_tgt_t unpack_tgt(input logic [WORD_W-1:0] w1,
                                             input logic [WORD_W-1:0] w2);
        beam_tgt_t t;
        t.v     = w1[15:8];
        t.h     = w1[7:1];
        t.vmask = w2[14:8];
        t.hmask = w2[7:1];
        t.skip  = w2[0];
        return t;
    endfunction

    function automatic logic is_end_marker(input beam_tgt_t t);
        return (t.v == 8'hFF) && (t.h == 7'h7F) && (t.vmask == 7'h7F) &&
               (t.hmask == 7'h7F) && !t.skip;
    endfunction

    function automatic logic move_permitted(input logic [REG_AW-1:0] off,
                                            input logic danger);
        return (off >= SAFE_FLOOR) || ((off >= DANGER_FLOOR) && danger);
    endfunction

endpackage

// File: rtl/coproc_ptrs.sv
module coproc_ptrs #(
    parameter int AW    = 20,
    parameter int NPTR  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [$clog2(NPTR)-1:0] sel,
    input  logic [AW-1:0]           wdata,
    output logic [AW-1:0]           ptr [NPTR]
);
    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        logic [AW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && (sel == i[$clog2(NPTR)-1:0]))
                q <= {wdata[AW-1:1], 1'b0};
        end
        assign ptr[i] = q;
    end
endmodule

// File: rtl/coproc_beamcmp.sv
module coproc_beamcmp
    import coproc_pkg::*;
(
    input  logic [7:0]        beam_v,
    input  logic [MASK_W-1:0] beam_h,
    input  beam_tgt_t         tgt,
    output logic              reached
);
    localparam int CMP_W = 8 + MASK_W;

    logic [CMP_W-1:0] now_pos;
    logic [CMP_W-1:0] tgt_pos;

    always_comb begin
        now_pos = {beam_v[7], beam_v[6:0] & tgt.vmask, beam_h & tgt.hmask};
        tgt_pos = {tgt.v[7],  tgt.v[6:0]  & tgt.vmask, tgt.h  & tgt.hmask};
        reached = (now_pos >= tgt_pos);
    end
endmodule

// File: rtl/coproc_seq.sv
module coproc_seq
    import coproc_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              danger_en,
    input  logic              restart,
    input  logic [AW-1:0]     restart_addr,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              beam_reached,
    output beam_tgt_t         cmp_tgt,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata
);
    localparam logic [AW-1:0] STEP_WORD = AW'(2);
    localparam logic [AW-1:0] STEP_SKIP = AW'(6);

    seq_state_e        state_q, state_n;
    logic [AW-1:0]     pc_q, pc_n;
    logic [WORD_W-1:0] w1_q, w1_n, w2_q, w2_n;
    logic              wr_n;
    logic              grant;
    logic [REG_AW-1:0] move_off;
    beam_tgt_t         fresh_tgt;

    assign mem_req  = dma_en && ((state_q == ST_FETCH1) || (state_q == ST_FETCH2));
    assign mem_addr = pc_q;
    assign grant    = mem_req && mem_gnt;
    assign move_off = {w1_q[8:1], 1'b0};
    assign fresh_tgt = unpack_tgt(w1_q, mem_rdata);
    assign cmp_tgt  = (state_q == ST_FETCH2) ? fresh_tgt : unpack_tgt(w1_q, w2_q);

    always_comb begin
        state_n = state_q;
        pc_n    = pc_q;
        w1_n    = w1_q;
        w2_n    = w2_q;
        wr_n    = 1'b0;
        if (restart) begin
            state_n = ST_FETCH1;
            pc_n    = restart_addr;
        end else if (dma_en) begin
            unique case (state_q)
                ST_FETCH1: if (grant) begin
                    w1_n    = mem_rdata;
                    pc_n    = pc_q + STEP_WORD;
                    state_n = ST_FETCH2;
                end
                ST_FETCH2: if (grant) begin
                    pc_n = pc_q + STEP_WORD;
                    if (!w1_q[0]) begin
                        if (move_permitted(move_off, danger_en)) begin
                            wr_n    = 1'b1;
                            state_n = ST_FETCH1;
                        end else begin
                            state_n = ST_HALT;
                        end
                    end else begin
                        w2_n = mem_rdata;
                        if (fresh_tgt.skip) begin
                            if (beam_reached) pc_n = pc_q + STEP_SKIP;
                            state_n = ST_FETCH1;
                        end else if (is_end_marker(fresh_tgt)) begin
                            state_n = ST_HALT;
                        end else begin
                            state_n = ST_WAIT;
                        end
                    end
                end
                ST_WAIT: if (beam_reached) state_n = ST_FETCH1;
                default: state_n = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_HALT;
            pc_q      <= '0;
            w1_q      <= '0;
            w2_q      <= '0;
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            state_q <= state_n;
            pc_q    <= pc_n;
            w1_q    <= w1_n;
            w2_q    <= w2_n;
            reg_we  <= wr_n;
            if (wr_n) begin
                reg_addr  <= move_off;
                reg_wdata <= mem_rdata;
            end
        end
    end

    // R9: every issued write lies in the permitted range
    assert_move_range_R9: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_addr >= DANGER_FLOOR) &&
                   ((reg_addr >= SAFE_FLOOR) || $past(danger_en)));

    // R2: two fetch slots separate consecutive writes
    assert_write_gap_R2: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R3: an unmet WAIT keeps the engine stalled with no fetch
    assert_wait_stall_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !beam_reached && !restart) |=>
        (state_q == ST_WAIT && !mem_req));

    // R6: a halted engine stays silent until restarted
    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && !restart) |=>
        (state_q == ST_HALT && !mem_req && !reg_we));

    // R10: with DMA off the program position does not move
    assert_dma_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        (!dma_en && !restart) |=> ($stable(pc_q) && $stable(state_q)));
endmodule

// File: rtl/beam_coproc.sv
module beam_coproc
    import coproc_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              danger_en,
    input  logic              ptr_we,
    input  logic              ptr_sel,
    input  logic [AW-1:0]     ptr_wdata,
    input  logic              frame_start,
    input  logic              jump_req,
    input  logic              jump_sel,
    input  logic [7:0]        beam_v,
    input  logic [6:0]        beam_h,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_gnt,
    input  logic [15:0]       mem_rdata,
    output logic              reg_we,
    output logic [8:0]        reg_addr,
    output logic [15:0]       reg_wdata
);
    localparam int NPTR = 2;

    logic [AW-1:0] ptr [NPTR];
    logic          restart;
    logic [AW-1:0] restart_addr;
    beam_tgt_t     cmp_tgt;
    logic          beam_reached;

    assign restart      = frame_start || jump_req;
    assign restart_addr = (frame_start || !jump_sel) ? ptr[0] : ptr[1];

    coproc_ptrs #(.AW(AW), .NPTR(NPTR)) u_ptrs (
        .clk   (clk),
        .rst   (rst),
        .we    (ptr_we),
        .sel   (ptr_sel),
        .wdata (ptr_wdata),
        .ptr   (ptr)
    );

    coproc_beamcmp u_cmp (
        .beam_v  (beam_v),
        .beam_h  (beam_h),
        .tgt     (cmp_tgt),
        .reached (beam_reached)
    );

    coproc_seq #(.AW(AW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .dma_en       (dma_en),
        .danger_en    (danger_en),
        .restart      (restart),
        .restart_addr (restart_addr),
        .mem_gnt      (mem_gnt),
        .mem_rdata    (mem_rdata),
        .beam_reached (beam_reached),
        .cmp_tgt      (cmp_tgt),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata)
    );
endmodule

// File: tb/sim_beam_coproc.sv
module sim_beam_coproc;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dma_en = 1'b0, danger_en = 1'b0;
    logic ptr_we = 1'b0, ptr_sel = 1'b0;
    logic [AW-1:0] ptr_wdata = '0;
    logic frame_start = 1'b0, jump_req = 1'b0, jump_sel = 1'b0;
    logic [7:0] beam_v = '0;
    logic [6:0] beam_h = '0;
    logic mem_req, mem_gnt = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_rdata;
    logic reg_we;
    logic [8:0] reg_addr;
    logic [15:0] reg_wdata;

    logic [15:0] mem [256];
    assign mem_rdata = mem[mem_addr[8:1]];

    int nchk = 0, nfail = 0, ncyc = 0, nlog = 0, t0 = 0, t1 = 0;
    logic [8:0]  log_addr [64];
    logic [15:0] log_data [64];
    int          log_cyc  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    beam_coproc #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .dma_en(dma_en), .danger_en(danger_en),
        .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
        .frame_start(frame_start), .jump_req(jump_req), .jump_sel(jump_sel),
        .beam_v(beam_v), .beam_h(beam_h),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    always @(negedge clk) begin
        ncyc = ncyc + 1;
        if (reg_we && nlog < 64) begin
            log_addr[nlog] = reg_addr;
            log_data[nlog] = reg_wdata;
            log_cyc[nlog]  = ncyc;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic put_move(input int w, input logic [8:0] off, input logic [15:0] d);
        mem[w] = {7'd0, off};
        mem[w+1] = d;
    endtask

    task automatic put_cmp(input int w, input logic [7:0] v, input logic [6:0] h,
                           input logic [6:0] vm, input logic [6:0] hm, input logic sk);
        mem[w] = {v, h, 1'b1};
        mem[w+1] = {1'b1, vm, hm, sk};
    endtask

    task automatic put_end(input int w);
        mem[w] = 16'hFFFF;
        mem[w+1] = 16'hFFFE;
    endtask

    task automatic set_ptr(input logic sel, input int addr);
        @(negedge clk); #1;
        ptr_sel = sel; ptr_wdata = AW'(addr); ptr_we = 1'b1;
        @(negedge clk); #1;
        ptr_we = 1'b0;
    endtask

    task automatic restart_frame();
        @(negedge clk); #1;
        nlog = 0;
        frame_start = 1'b1; t0 = ncyc;
        @(negedge clk); #1;
        frame_start = 1'b0;
    endtask

    task automatic do_jump(input logic sel, input logic with_frame);
        @(negedge clk); #1;
        nlog = 0;
        jump_sel = sel; jump_req = 1'b1; frame_start = with_frame; t0 = ncyc;
        @(negedge clk); #1;
        jump_req = 1'b0; frame_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 mem_req after reset", int'(mem_req), 0);
        chk("R11 reg_we after reset", int'(reg_we), 0);
        nlog = 0;
        run(6);
        chk("R11 no writes before restart", nlog, 0);
        chk("R11 still idle", int'(mem_req), 0);
        // pointer 1 is zero: a jump with no pointer write fetches address 0
        put_move(0, 9'h1C0, 16'h0C0C);
        put_end(2);
        dma_en = 1'b1;
        do_jump(1'b0, 1'b0);
        run(8);
        chk("R11 reset pointer is zero", nlog, 1);
        chk("R11 write from address 0", int'(log_addr[0]), 'h1C0);
    endtask

    task automatic t_moves();
        put_move(16, 9'h180, 16'h0F00);
        put_move(18, 9'h182, 16'h00F0);
        put_end(20);
        set_ptr(1'b0, 32);
        restart_frame();
        run(12);
        chk("R1 write count", nlog, 2);
        chk("R1 first offset", int'(log_addr[0]), 'h180);
        chk("R1 first data", int'(log_data[0]), 'h0F00);
        chk("R7 first write three edges after frame start", log_cyc[0], t0 + 3);
        chk("R2 second write two cycles later", log_cyc[1], t0 + 5);
        chk("R1 second data", int'(log_data[1]), 'h00F0);
        chk("R6 idle after end marker", int'(mem_req), 0);
    endtask

    task automatic t_grant();
        mem_gnt = 1'b0;
        restart_frame();
        run(6);
        chk("R2 no progress without grant", nlog, 0);
        chk("R2 request held", int'(mem_req), 1);
        chk("R2 request address", int'(mem_addr), 32);
        mem_gnt = 1'b1; t1 = ncyc;
        run(8);
        chk("R2 write after grant", log_cyc[0], t1 + 2);
        chk("R2 writes after grant", nlog, 2);
    endtask

    task automatic t_wait();
        put_cmp(32, 8'h20, 7'h20, 7'h7F, 7'h7F, 1'b0);
        put_move(34, 9'h190, 16'h1234);
        put_end(36);
        set_ptr(1'b0, 64);
        beam_v = 8'h10; beam_h = 7'h00;
        restart_frame();
        run(10);
        chk("R3 no write before target", nlog, 0);
        chk("R3 no request while waiting", int'(mem_req), 0);
        beam_v = 8'h20; beam_h = 7'h1F;
        run(5);
        chk("R3 one short of target", nlog, 0);
        beam_h = 7'h20; t1 = ncyc;
        run(6);
        chk("R3 released at equality", nlog, 1);
        chk("R3 release latency", log_cyc[0], t1 + 3);
        chk("R3 data after wait", int'(log_data[0]), 'h1234);
    endtask

    task automatic t_mask();
        put_cmp(48, 8'h05, 7'h10, 7'h00, 7'h7F, 1'b0);
        put_move(50, 9'h192, 16'hAAAA);
        put_end(52);
        set_ptr(1'b0, 96);
        beam_v = 8'h03; beam_h = 7'h00;
        restart_frame();
        run(8);
        chk("R4 masked vertical, horizontal low", nlog, 0);
        beam_h = 7'h10; t1 = ncyc;
        run(6);
        chk("R4 masked vertical ignored", log_cyc[0], t1 + 3);
        // bit 7 of vertical stays in the compare
        put_cmp(48, 8'h80, 7'h00, 7'h00, 7'h00, 1'b0);
        beam_v = 8'h7F; beam_h = 7'h7F;
        restart_frame();
        run(8);
        chk("R4 vertical bit 7 compared", nlog, 0);
        beam_v = 8'h80; t1 = ncyc;
        run(6);
        chk("R4 release on bit 7", log_cyc[0], t1 + 3);
    endtask

    task automatic t_skip();
        put_cmp(64, 8'h10, 7'h00, 7'h7F, 7'h7F, 1'b1);
        put_move(66, 9'h1A0, 16'h0001);
        put_move(68, 9'h1A2, 16'h0002);
        put_end(70);
        set_ptr(1'b0, 128);
        beam_v = 8'h20; beam_h = 7'h00;
        restart_frame();
        run(12);
        chk("R5 skip taken count", nlog, 1);
        chk("R5 skip taken offset", int'(log_addr[0]), 'h1A2);
        beam_v = 8'h05;
        restart_frame();
        run(12);
        chk("R5 skip not taken count", nlog, 2);
        chk("R5 skip not taken first", int'(log_addr[0]), 'h1A0);
    endtask

    task automatic t_protect();
        put_move(80, 9'h03E, 16'h0005);
        put_move(82, 9'h184, 16'h0006);
        put_end(84);
        set_ptr(1'b0, 160);
        danger_en = 1'b1;
        restart_frame();
        run(10);
        chk("R9 offset below 0x040 aborts", nlog, 0);
        chk("R9 halted after abort", int'(mem_req), 0);
        put_move(80, 9'h040, 16'h0007);
        danger_en = 1'b0;
        restart_frame();
        run(10);
        chk("R9 danger range blocked", nlog, 0);
        danger_en = 1'b1;
        restart_frame();
        run(10);
        chk("R9 danger range allowed count", nlog, 2);
        chk("R9 danger range offset", int'(log_addr[0]), 'h040);
        danger_en = 1'b0;
    endtask

    task automatic t_jump();
        put_move(96, 9'h1B0, 16'h00A1);
        put_end(98);
        put_move(104, 9'h1B2, 16'h00B2);
        put_end(106);
        set_ptr(1'b0, 192);
        set_ptr(1'b1, 208);
        do_jump(1'b1, 1'b0);
        run(8);
        chk("R8 jump to list 2", int'(log_addr[0]), 'h1B2);
        chk("R8 jump latency", log_cyc[0], t0 + 3);
        do_jump(1'b0, 1'b0);
        run(8);
        chk("R8 jump to list 1", int'(log_addr[0]), 'h1B0);
        do_jump(1'b1, 1'b1);
        run(8);
        chk("R7 frame start beats jump", int'(log_addr[0]), 'h1B0);
    endtask

    task automatic t_dma();
        put_move(112, 9'h1D0, 16'h0011);
        put_move(114, 9'h1D2, 16'h0022);
        put_move(116, 9'h1D4, 16'h0033);
        put_move(118, 9'h1D6, 16'h0044);
        put_end(120);
        set_ptr(1'b0, 224);
        dma_en = 1'b0;
        restart_frame();
        run(8);
        chk("R10 no writes while disabled", nlog, 0);
        chk("R10 no request while disabled", int'(mem_req), 0);
        dma_en = 1'b1; t1 = ncyc;
        run(3);
        dma_en = 1'b0;
        run(8);
        chk("R10 frozen mid list", nlog, 1);
        chk("R10 frozen request", int'(mem_req), 0);
        dma_en = 1'b1; t1 = ncyc;
        run(10);
        chk("R10 all writes after resume", nlog, 4);
        chk("R10 resumed instruction", int'(log_addr[1]), 'h1D2);
        chk("R10 resume latency", log_cyc[1], t1 + 1);
        chk("R10 last instruction", int'(log_addr[3]), 'h1D6);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
        run(3);
        rst = 1'b0;
        run(1);
        t_reset();
        t_moves();
        t_grant();
        t_wait();
        t_mask();
        t_skip();
        t_protect();
        t_jump();
        t_dma();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule